// File: doc/BRIEF.md
# FP32 to FP4 E2M1 Stream Encoder

This block narrows single-precision floating-point values to the 4-bit E2M1 format. Each code holds a sign bit, a two-bit exponent with bias 1 and one mantissa bit. The magnitudes it can represent are 0, 0.5, 1, 1.5, 2, 3, 4 and 6. The format has no infinity and no NaN code.

Each input beat carries four fp32 lanes. The block converts all four in parallel and packs them two codes per byte into a 16-bit output word. Both sides use a valid/ready handshake, with one register stage between them.

Rounding is always round-to-nearest-even, and out-of-range values always saturate. Neither behaviour can be configured.

Top module: `fp4_stream_enc`

## Requirements
- R1: A code nibble is {sign, e[1:0], m}. For e>0 its magnitude is (1 + m/2)·2^(e−1). For e=0 its magnitude is m·0.5. Every fp32 input whose magnitude is exactly one of these values encodes to that code, keeping the input's sign.
- R2: An fp32 NaN (exponent field 255, non-zero fraction) encodes as magnitude bits 000 with the input's sign bit kept.
- R3: An input of magnitude 8 or more, including fp32 infinity, encodes as sign|111 (magnitude 6).
- R4: A finite input of magnitude at least 1 and below 6 that is not on the grid encodes to the nearest grid magnitude. An exact tie goes to the code whose mantissa bit is 0.
- R5: A magnitude in [6, 8) encodes as sign|111, including values that would round up to 8.
- R6: Magnitudes below 0.25, including fp32 subnormals and zeros, encode as signed zero. Exactly 0.25 also encodes as zero. Magnitudes strictly between 0.25 and 0.75 encode as 0.5 (code 001). Exactly 0.75 encodes as 1.0 (code 010).
- R7: Lane 0 goes to out_data[3:0], lane 1 to out_data[7:4], lane 2 to out_data[11:8] and lane 3 to out_data[15:12]. Lane k is taken from in_data[32k+31:32k].
- R8: A beat accepted on a clock edge (in_valid and in_ready both high) appears on the output after that edge. in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R9: While rst is high and after it is released, out_valid is low until the first beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 128 | Four fp32 lanes, lane 0 in the low bits |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 16 | Four packed E2M1 codes, lane 0 in the low nibble |

## Verification
The encoder is swept over fp32 exponent fields from well below the smallest step to well above saturation. The sweep crosses all sixteen values of the top four fraction bits with three low-bit patterns (zero, a single low bit, all ones) and both signs. This separates exact grid points from exact ties and from values just past a tie, so rounding direction and tie-to-even are told apart at every binade, including the subnormal step and the edge of saturation.

NaNs, infinities, zeros and fp32 subnormals are placed in different lanes of the same beat to expose nibble misplacement. A stall with out_ready low shows whether the output word and the handshake hold.

// File: rtl/fp4_pkg.sv
package fp4_pkg;

    localparam int FP32_W   = 32;
    localparam int FP4_W    = 4;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;

    // fp32 exponent fields that bound the encoder's regions
    localparam logic [EXP_W-1:0] EXP_SPECIAL  = 8'hFF;
    localparam logic [EXP_W-1:0] EXP_TOP_NORM = 8'd129;  // [4,8)
    localparam logic [EXP_W-1:0] EXP_ONE      = 8'd127;  // [1,2)
    localparam logic [EXP_W-1:0] EXP_HALF     = 8'd126;  // [0.5,1)
    localparam logic [EXP_W-1:0] EXP_QUARTER  = 8'd125;  // [0.25,0.5)

    localparam logic [2:0] MAG_ZERO = 3'b000;
    localparam logic [2:0] MAG_HALF = 3'b001;
    localparam logic [2:0] MAG_ONE  = 3'b010;
    localparam logic [2:0] MAG_MAX  = 3'b111;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp32_t;

    typedef struct packed {
        logic       sign;
        logic [1:0] exp;
        logic       man;
    } fp4_t;

    function automatic logic is_nan(fp32_t f);
        return (f.exp == EXP_SPECIAL) && (f.frac != '0);
    endfunction

    // round-up decision at the single kept mantissa bit (nearest, ties even)
    function automatic logic rne_up(fp32_t f);
        logic guard_b;
        logic sticky_b;
        guard_b  = f.frac[FRAC_W-2];
        sticky_b = |f.frac[FRAC_W-3:0];
        return guard_b & (sticky_b | f.frac[FRAC_W-1]);
    endfunction

endpackage

// File: rtl/fp4_lane_enc.sv
module fp4_lane_enc
    import fp4_pkg::*;
(
    input  logic [FP32_W-1:0] in_bits,
    output logic [FP4_W-1:0]  code
);

    fp32_t      f;
    logic [7:0] exp_off;
    logic [3:0] base;
    logic [3:0] rounded;
    logic [2:0] mag;
    fp4_t       res;

    assign f       = fp32_t'(in_bits);
    assign exp_off = f.exp - EXP_HALF;
    assign base    = {1'b0, exp_off[1:0], f.frac[FRAC_W-1]};
    assign rounded = base + {3'b000, rne_up(f)};

    always_comb begin
        mag = MAG_ZERO;
        if (f.exp == EXP_SPECIAL) begin
            mag = is_nan(f) ? MAG_ZERO : MAG_MAX;
        end else if (f.exp > EXP_TOP_NORM) begin
            mag = MAG_MAX;
        end else if (f.exp >= EXP_ONE) begin
            // carry out of the top binade means the value rounded to 8
            mag = rounded[3] ? MAG_MAX : rounded[2:0];
        end else if (f.exp == EXP_HALF) begin
            mag = f.frac[FRAC_W-1] ? MAG_ONE : MAG_HALF;
        end else if (f.exp == EXP_QUARTER) begin
            mag = (f.frac != '0) ? MAG_HALF : MAG_ZERO;
        end else begin
            mag = MAG_ZERO;
        end
    end

    always_comb begin
        res.sign = f.sign;
        res.exp  = mag[2:1];
        res.man  = mag[0];
    end

    assign code = res;

endmodule

// File: rtl/fp4_nibble_pack.sv
module fp4_nibble_pack
    import fp4_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*FP4_W-1:0] codes,
    output logic [LANES*FP4_W-1:0] packed_word
);

    localparam int BYTES = LANES / 2;

    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            // even lane low nibble, odd lane high nibble
            assign packed_word[8*b +: FP4_W]         = codes[(2*b)*FP4_W +: FP4_W];
            assign packed_word[8*b + FP4_W +: FP4_W] = codes[(2*b+1)*FP4_W +: FP4_W];
        end
    endgenerate

endmodule

// File: rtl/fp4_stream_enc.sv
module fp4_stream_enc
    import fp4_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [127:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [15:0]  out_data
);

    localparam int LANES = 4;
    localparam int IN_W  = LANES * FP32_W;
    localparam int OUT_W = LANES * FP4_W;

    logic [OUT_W-1:0] codes;
    logic [OUT_W-1:0] packed_word;
    logic [OUT_W-1:0] data_q;
    logic             valid_q;
    logic             accept;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            fp4_lane_enc u_enc (
                .in_bits (in_data[l*FP32_W +: FP32_W]),
                .code    (codes[l*FP4_W +: FP4_W])
            );
        end
    endgenerate

    fp4_nibble_pack #(.LANES(LANES)) u_pack (
        .codes       (codes),
        .packed_word (packed_word)
    );

    assign in_ready = !valid_q || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (in_ready) begin
            valid_q <= in_valid;
            if (in_valid) data_q <= packed_word;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = data_q;

    // R8: stalled word holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: accepted beat shows up next cycle
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R2: lane 0 NaN gives signed zero
    p_nan_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && in_data[30:23] == 8'hFF && in_data[22:0] != '0)
        |=> (out_data[2:0] == 3'b000 && out_data[3] == $past(in_data[31])));

    // R3: lane 0 at or above 8 saturates
    p_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && in_data[30:23] > 8'd129 && in_data[30:23] != 8'hFF)
        |=> (out_data[2:0] == 3'b111));

    // R6: lane 0 below 0.25 flushes to zero
    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && in_data[30:23] < 8'd125) |=> (out_data[2:0] == 3'b000));

endmodule

// File: tb/tb_fp4_stream_enc.sv
module tb_fp4_stream_enc;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [15:0]  out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    fp4_stream_enc dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic real grid_val(int i);
        case (i)
            0: return 0.0;  1: return 0.5;  2: return 1.0;  3: return 1.5;
            4: return 2.0;  5: return 3.0;  6: return 4.0;  default: return 6.0;
        endcase
    endfunction

    function automatic real mag_of(logic [31:0] x);
        int  e;
        real v;
        e = int'(x[30:23]);
        v = (e == 0) ? real'(x[22:0]) : (1.0 + real'(x[22:0]) / 8388608.0);
        if (e == 0) e = -22; else e = e - 127;   // subnormal: frac * 2^-149
        if (x[30:23] == 8'd0) e = -149;
        while (e > 0) begin v = v * 2.0; e--; end
        while (e < 0) begin v = v / 2.0; e++; end
        return v;
    endfunction

    function automatic logic [3:0] model(logic [31:0] x);
        real v;
        int  idx;
        if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? {x[31], 3'b000} : {x[31], 3'b111};
        v = mag_of(x);
        if (v >= 6.0) return {x[31], 3'b111};
        idx = 0;
        for (int i = 0; i < 7; i++) if (v >= grid_val(i)) idx = i;
        if (v != grid_val(idx)) begin
            real d_lo, d_hi;
            d_lo = v - grid_val(idx);
            d_hi = grid_val(idx + 1) - v;
            if (d_hi < d_lo || (d_hi == d_lo && (idx % 2) == 1)) idx = idx + 1;
        end
        return {x[31], 3'(idx)};
    endfunction

    function automatic string req_of(logic [31:0] x);
        real v;
        if (x[30:23] == 8'hFF) return (x[22:0] != 0) ? "R2" : "R3";
        v = mag_of(x);
        if (v >= 8.0) return "R3";
        if (v >= 6.0) return "R5";
        if (v <= 0.75) return "R6";
        for (int i = 0; i < 8; i++) if (v == grid_val(i)) return "R1";
        return "R4";
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    // send one beat with out_ready high and check all four nibbles (R7 positions)
    task automatic beat(logic [31:0] l0, logic [31:0] l1, logic [31:0] l2, logic [31:0] l3);
        logic [31:0] lanes [4];
        lanes[0] = l0; lanes[1] = l1; lanes[2] = l2; lanes[3] = l3;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {l3, l2, l1, l0};
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "out_valid after accept", 32'(out_valid), 32'd1);
        for (int k = 0; k < 4; k++)
            check(req_of(lanes[k]), $sformatf("R7 lane %0d code for %h", k, lanes[k]),
                  32'(out_data[4*k +: 4]), 32'(model(lanes[k])));
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] q [$];
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "out_valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R8", "in_ready when empty", 32'(in_ready), 32'd1);

        // specials spread across lanes: NaN, -inf, -0, subnormal (R2 R3 R6 R7)
        beat(32'h7FC00001, 32'hFF800000, 32'h80000000, 32'h00000123);
        beat(32'hFFC00000, 32'h00400000, 32'h7F800000, 32'h3F400000);
        // named corner values: 0.25, 0.75, 5.0, 7.0 (R6 R4 R5)
        beat(32'h3E800000, 32'h3F400000, 32'h40A00000, 32'h40E00000);
        // 8.0, 6.0, 2.5, 1.25 (R3 R1 R4)
        beat(32'h41000000, 32'h40C00000, 32'h40200000, 32'h3FA00000);

        // sweep exponents x top fraction bits x low patterns x sign
        for (int e = 100; e <= 160; e++)
            for (int t = 0; t < 16; t++)
                for (int lo = 0; lo < 3; lo++)
                    for (int s = 0; s < 2; s++) begin
                        logic [18:0] low;
                        low = (lo == 0) ? 19'd0 : (lo == 1) ? 19'd1 : 19'h7FFFF;
                        q.push_back({1'(s), 8'(e), 4'(t), low});
                    end
        while (q.size() >= 4) begin
            logic [31:0] a, b, c, d;
            a = q.pop_front(); b = q.pop_front(); c = q.pop_front(); d = q.pop_front();
            beat(a, b, c, d);
        end

        // R8: stall holds word and drops in_ready
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = {32'h40C00000, 32'hBF800000, 32'h3F000000, 32'h40400000};
        @(negedge clk);
        in_data   = {4{32'h7FC00000}};
        check("R8", "in_ready while stalled", 32'(in_ready), 32'd0);
        check("R8", "stalled word", 32'(out_data), 32'h7A15);
        repeat (3) @(negedge clk);
        check("R8", "stalled word held", 32'(out_data), 32'h7A15);
        check("R8", "out_valid held", 32'(out_valid), 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "next word after release", 32'(out_data), 32'h0000);
        @(negedge clk);
        check("R8", "out_valid drops when idle", 32'(out_valid), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule